// File: doc/BRIEF.md
# Paged MDIO Management Register Slave

This block is the management-side register slave of a PHY. It decodes serial management frames (preamble, start, opcode, PHY address, register address, turnaround, 16 data bits) clocked by MDC, and it answers on two PHY addresses. PHY address 1 is a paged space. Registers 0 to 15 form one bank that every page shares. Register 31 selects the page. Registers 16 to 30 belong to whichever page is selected. PHY address 2 holds a small set of extended registers that are not paged. Software reaches them through an offset port and a data port.

The block samples MDC and MDIO with the system clock. It acts on each rising edge of MDC and changes its MDIO output a few system cycles after that edge. After reset it refuses every frame until a parameterised number of clock cycles has elapsed. After that it accepts a frame only while the `access_ready` input is high. Permission is decided once per frame, at the last register-address bit.

Top module: `mdio_paged_slave`

## Requirements
- R1: After reset, MDIO is not driven, the page register is 0, and every implemented register reads as zero.
- R2: A frame is recognised only after at least 32 consecutive ones, then start bits 0,1, then opcode 1,0 (read) or 0,1 (write), then 5 PHY-address bits and 5 register-address bits, all MSB first. On an accepted read the slave leaves the first turnaround bit undriven and drives the second as 0. It then drives 16 data bits MSB first and releases MDIO on the bit after D0. A write frame is never driven.
- R3: Only PHY addresses 1 and 2 get a response. A frame to any other address leaves MDIO undriven and changes no register.
- R4: Under PHY address 1, registers 0 to 15 are one bank shared by every page.
- R5: A write to register 31 of PHY address 1 sets the page to bits 15:5 of the data, and bits 4:0 are ignored. A read of register 31 returns the page in bits 15:5 with bits 4:0 zero.
- R6: Under PHY address 1, registers 16 to 30 are held separately for each of pages 0 to NUM_PAGES-1 (default 4).
- R7: While the page is NUM_PAGES or higher, reads of registers 16 to 30 return zero and writes to them are discarded.
- R8: Under PHY address 2, register 16 is an offset port that holds its full 16-bit value and reads it back. Register 17 is a data port to extended register [offset]. An offset of NUM_EXT (default 8) or more reads zero and discards writes. Every other register at PHY address 2 reads zero and ignores writes.
- R9: For WAIT_CYCLES clock cycles after reset, every frame is ignored.
- R10: A frame is accepted only if `access_ready` is high when its last register-address bit is sampled. A later change of `access_ready` does not affect that frame.
- R11: A frame with opcode 0,0 or 1,1 is dropped. The line is not driven and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| access_ready | input | 1 | Status flag permitting register access |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | MDIO line as seen at the pad |
| mdio_out | output | 1 | Value the slave drives on MDIO |
| mdio_oe | output | 1 | High while the slave drives MDIO |

## Verification
Two functions can meet in a single frame: the access gate, where `access_ready` changes, and the commit of a write that was already granted. The bench starts a write to a shared register with `access_ready` high and drops the flag midway through the data bits. Once the flag is high again, it reads the register back. The result passes only if the full data word landed, which shows that permission is latched at the register address and not rechecked at commit. A companion case holds the flag low through the address. It passes only if that write leaves no trace.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the paged MDIO slave.
// Assumes Clause 22 framing with 5-bit PHY and register addresses.
package mdio_pkg;
    localparam logic [4:0] PHY_GEN   = 5'd1;   // paged general space
    localparam logic [4:0] PHY_EXT   = 5'd2;   // indirect extended space
    localparam logic [4:0] REG_PAGE  = 5'd31;  // page select register
    localparam logic [4:0] REG_XOFS  = 5'd16;  // extended offset port
    localparam logic [4:0] REG_XDAT  = 5'd17;  // extended data port
    localparam logic [5:0] PRE_ONES  = 6'd32;  // minimum preamble length

    typedef enum logic [2:0] {
        FS_PRE, FS_ST, FS_OP, FS_ADR, FS_TA, FS_RD, FS_WD
    } frame_state_t;
endpackage

// File: rtl/mdio_access_gate.sv
// Access gate: counts WAIT_CYCLES clocks after reset, then grants access
// while the ready flag is high. Assumes WAIT_CYCLES >= 1.
module mdio_access_gate #(
    parameter int WAIT_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access_ready,
    output logic wait_done,
    output logic allowed
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYCLES);

    logic [CW-1:0] cnt_q;

    // Post-reset wait counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign wait_done = (cnt_q == LIMIT);
    assign allowed   = wait_done && access_ready;

    // Once open, the wait never closes again until reset (R9).
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_done |=> wait_done);
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: walks preamble, start, opcode, address, turnaround and data
// one MDC bit at a time. Latches permission at the last address bit, loads
// read data at turnaround and pulses wr_en after the 16th write bit.
// Assumes bit_strobe is a one-cycle pulse per rising MDC edge.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_strobe,
    input  logic        bit_val,
    input  logic        access_ok,
    input  logic [15:0] rd_data,
    output logic        wr_en,
    output logic [15:0] wr_data,
    output logic        ext_sel,
    output logic [4:0]  reg_adr,
    output logic        mdio_out,
    output logic        mdio_oe
);
    frame_state_t state_q;
    logic [5:0]   ones_q;
    logic [4:0]   cnt_q;
    logic [15:0]  sr_q;
    logic         op_hi_q, is_rd_q, active_q;
    logic [9:0]   adr_full;

    assign adr_full = {sr_q[8:0], bit_val};

    // Per-bit frame sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_PRE;  ones_q <= '0;  cnt_q <= '0;  sr_q <= '0;
            op_hi_q <= 1'b0;    is_rd_q <= 1'b0; active_q <= 1'b0;
            wr_en <= 1'b0;      wr_data <= '0;  ext_sel <= 1'b0;
            reg_adr <= '0;      mdio_out <= 1'b0; mdio_oe <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (bit_strobe) begin
                case (state_q)
                    FS_PRE: begin
                        if (bit_val) begin
                            if (ones_q != PRE_ONES) ones_q <= ones_q + 1'b1;
                        end else begin
                            if (ones_q == PRE_ONES) state_q <= FS_ST;
                            ones_q <= '0;
                        end
                    end
                    FS_ST: begin
                        state_q <= bit_val ? FS_OP : FS_PRE;
                        cnt_q   <= '0;
                    end
                    FS_OP: begin
                        if (cnt_q == 5'd0) begin
                            op_hi_q <= bit_val;
                            cnt_q   <= 5'd1;
                        end else begin
                            cnt_q <= '0;
                            if (op_hi_q != bit_val) begin
                                is_rd_q <= op_hi_q;
                                state_q <= FS_ADR;
                            end else begin
                                state_q <= FS_PRE;
                            end
                        end
                    end
                    FS_ADR: begin
                        sr_q <= {sr_q[14:0], bit_val};
                        if (cnt_q == 5'd9) begin
                            ext_sel  <= (adr_full[9:5] == PHY_EXT);
                            reg_adr  <= adr_full[4:0];
                            active_q <= access_ok &&
                                        ((adr_full[9:5] == PHY_GEN) ||
                                         (adr_full[9:5] == PHY_EXT));
                            cnt_q    <= '0;
                            state_q  <= FS_TA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FS_TA: begin
                        if (is_rd_q) begin
                            mdio_oe  <= active_q;
                            mdio_out <= 1'b0;
                            sr_q     <= rd_data;
                            cnt_q    <= '0;
                            state_q  <= FS_RD;
                        end else if (cnt_q == 5'd0) begin
                            cnt_q <= 5'd1;
                        end else begin
                            cnt_q   <= '0;
                            state_q <= FS_WD;
                        end
                    end
                    FS_RD: begin
                        if (cnt_q == 5'd16) begin
                            mdio_oe <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= FS_PRE;
                        end else begin
                            mdio_out <= sr_q[15];
                            sr_q     <= {sr_q[14:0], 1'b0};
                            cnt_q    <= cnt_q + 1'b1;
                        end
                    end
                    FS_WD: begin
                        sr_q <= {sr_q[14:0], bit_val};
                        if (cnt_q == 5'd15) begin
                            wr_en   <= active_q;
                            wr_data <= {sr_q[14:0], bit_val};
                            cnt_q   <= '0;
                            state_q <= FS_PRE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= FS_PRE;
                endcase
            end
        end
    end

    // The first bit the slave drives is the zero turnaround bit (R2).
    p_ta_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);
    // Write frames never drive the line (R2).
    p_wr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> is_rd_q);
    // A write commit never coincides with driving the line (R2).
    p_wr_not_drv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !mdio_oe);
endmodule

// File: rtl/mdio_reg_space.sv
// Register space: shared IEEE bank, page register, per-page banks built by
// generate, and the offset/data pair for the extended bank. Reads are
// combinational on the latched address; writes commit on wr_en.
// Assumes NUM_PAGES >= 2 and NUM_EXT >= 2.
module mdio_reg_space
    import mdio_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int NUM_EXT   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        ext_sel,
    input  logic [4:0]  reg_adr,
    output logic [15:0] rd_data
);
    localparam int PSEL_W = $clog2(NUM_PAGES);
    localparam int XSEL_W = $clog2(NUM_EXT);
    localparam logic [10:0] PAGE_LIM = 11'(NUM_PAGES);
    localparam logic [15:0] EXT_LIM  = 16'(NUM_EXT);

    logic [15:0] common_q [16];
    logic [15:0] ext_q [NUM_EXT];
    logic [15:0] pg_rd [NUM_PAGES];
    logic [10:0] page_q;
    logic [15:0] offset_q;
    logic        page_ok, ofs_ok, in_page_rng, pg_we;
    logic [3:0]  reg_lo;

    assign page_ok     = (page_q < PAGE_LIM);
    assign ofs_ok      = (offset_q < EXT_LIM);
    assign in_page_rng = reg_adr[4] && (reg_adr != REG_PAGE);
    assign reg_lo      = reg_adr[3:0];
    assign pg_we       = wr_en && !ext_sel && in_page_rng && page_ok;

    // Shared bank, page register, offset port and extended bank writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++)      common_q[i] <= '0;
            for (int i = 0; i < NUM_EXT; i++) ext_q[i] <= '0;
            page_q   <= '0;
            offset_q <= '0;
        end else if (wr_en) begin
            if (!ext_sel) begin
                if (!reg_adr[4])              common_q[reg_lo] <= wr_data;
                else if (reg_adr == REG_PAGE) page_q <= wr_data[15:5];
            end else begin
                if (reg_adr == REG_XOFS)               offset_q <= wr_data;
                else if (reg_adr == REG_XDAT && ofs_ok) ext_q[offset_q[XSEL_W-1:0]] <= wr_data;
            end
        end
    end

    // One bank of registers 16..30 per implemented page.
    for (genvar gp = 0; gp < NUM_PAGES; gp++) begin : g_page
        logic [15:0] cell_q [15];

        // Write this page's cell when it is the selected page.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < 15; i++) cell_q[i] <= '0;
            end else if (pg_we && (page_q[PSEL_W-1:0] == PSEL_W'(gp))) begin
                cell_q[reg_lo] <= wr_data;
            end
        end

        assign pg_rd[gp] = cell_q[reg_lo];
    end

    // Read mux over both PHY addresses.
    always_comb begin
        rd_data = '0;
        if (!ext_sel) begin
            if (!reg_adr[4])              rd_data = common_q[reg_lo];
            else if (reg_adr == REG_PAGE) rd_data = {page_q, 5'b0};
            else if (page_ok)             rd_data = pg_rd[page_q[PSEL_W-1:0]];
        end else begin
            if (reg_adr == REG_XOFS)               rd_data = offset_q;
            else if (reg_adr == REG_XDAT && ofs_ok) rd_data = ext_q[offset_q[XSEL_W-1:0]];
        end
    end

    // A page-register write loads bits 15:5 (R5).
    p_page_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ext_sel && reg_adr == REG_PAGE) |=> page_q == $past(wr_data[15:5]));
    // Any other write leaves the page unchanged (R4).
    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !ext_sel && reg_adr == REG_PAGE) |=> $stable(page_q));
    // The offset only moves on an offset-port write (R8).
    p_ofs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ext_sel && reg_adr == REG_XOFS) |=> $stable(offset_q));
endmodule

// File: rtl/mdio_paged_slave.sv
// Top: synchronises MDC/MDIO into the system clock, finds rising MDC edges
// and ties the access gate, frame engine and register space together.
// Assumes MDC half-period spans at least four system clocks.
module mdio_paged_slave #(
    parameter int WAIT_CYCLES = 500000,
    parameter int NUM_PAGES   = 4,
    parameter int NUM_EXT     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access_ready,
    input  logic mdc,
    input  logic mdio_in,
    output logic mdio_out,
    output logic mdio_oe
);
    logic [1:0]  mdc_s, mdio_s;
    logic        mdc_d, bit_strobe;
    logic        wait_done, allowed;
    logic        wr_en, ext_sel;
    logic [15:0] wr_data, rd_data;
    logic [4:0]  reg_adr;

    // Two-stage input synchroniser plus edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_s <= '0; mdio_s <= 2'b11; mdc_d <= 1'b0;
        end else begin
            mdc_s  <= {mdc_s[0], mdc};
            mdio_s <= {mdio_s[0], mdio_in};
            mdc_d  <= mdc_s[1];
        end
    end

    assign bit_strobe = mdc_s[1] && !mdc_d;

    mdio_access_gate #(.WAIT_CYCLES(WAIT_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .access_ready(access_ready),
        .wait_done(wait_done), .allowed(allowed)
    );

    mdio_frame_engine u_frame (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_val(mdio_s[1]),
        .access_ok(allowed), .rd_data(rd_data), .wr_en(wr_en),
        .wr_data(wr_data), .ext_sel(ext_sel), .reg_adr(reg_adr),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    mdio_reg_space #(.NUM_PAGES(NUM_PAGES), .NUM_EXT(NUM_EXT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ext_sel(ext_sel), .reg_adr(reg_adr), .rd_data(rd_data)
    );

    // No register write may land before the post-reset wait has run (R9).
    p_wr_after_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wait_done);
    // The line is never driven before the post-reset wait has run (R9).
    p_drv_after_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> wait_done);
endmodule

// File: tb/sim_mdio_paged_slave.sv
// Bench: table of frames walked by one loop, then directed tests.
module sim_mdio_paged_slave;
    localparam int WAIT = 2000;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic access_ready = 1'b1;
    logic mdc = 1'b0;
    logic mdio_in = 1'b1;
    logic mdio_out, mdio_oe;

    int n_chk = 0;
    int n_bad = 0;
    int bit_no = 0;
    int drop_bit = -1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mdio_paged_slave #(.WAIT_CYCLES(WAIT), .NUM_PAGES(4), .NUM_EXT(8)) u0 (
        .clk(clk), .rst_n(rst_n), .access_ready(access_ready), .mdc(mdc),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    // Fields: op[48:47] phy[46:42] reg[41:37] wdata[36:21] exp[20:5] drv[4] req[3:0]
    localparam int NV = 35;
    localparam logic [48:0] VEC [NV] = '{
        {2'b01,5'd1,5'd31,16'h0045,16'h0000,1'b0,4'd5},  // R5 page 2, low bits ignored
        {2'b10,5'd1,5'd31,16'h0000,16'h0040,1'b1,4'd5},  // R5 readback
        {2'b01,5'd1,5'd16,16'h1111,16'h0000,1'b0,4'd6},  // R6 page2 r16
        {2'b01,5'd1,5'd4 ,16'hABCD,16'h0000,1'b0,4'd4},  // R4 shared reg
        {2'b01,5'd1,5'd31,16'h0020,16'h0000,1'b0,4'd5},  // page 1
        {2'b10,5'd1,5'd16,16'h0000,16'h0000,1'b1,4'd6},  // R6 page1 r16 empty
        {2'b10,5'd1,5'd4 ,16'h0000,16'hABCD,1'b1,4'd4},  // R4 shared on page1
        {2'b01,5'd1,5'd30,16'h2222,16'h0000,1'b0,4'd6},  // page1 r30
        {2'b01,5'd1,5'd31,16'h0040,16'h0000,1'b0,4'd5},  // page 2
        {2'b10,5'd1,5'd16,16'h0000,16'h1111,1'b1,4'd6},  // R6
        {2'b10,5'd1,5'd30,16'h0000,16'h0000,1'b1,4'd6},  // R6 page2 r30 empty
        {2'b01,5'd1,5'd31,16'h00A0,16'h0000,1'b0,4'd7},  // page 5 unimplemented
        {2'b01,5'd1,5'd20,16'h3333,16'h0000,1'b0,4'd7},  // R7 discarded
        {2'b10,5'd1,5'd20,16'h0000,16'h0000,1'b1,4'd7},  // R7 reads zero
        {2'b10,5'd1,5'd31,16'h0000,16'h00A0,1'b1,4'd5},  // R5 page 5 readback
        {2'b10,5'd1,5'd4 ,16'h0000,16'hABCD,1'b1,4'd4},  // R4 shared on page5
        {2'b01,5'd1,5'd31,16'h0020,16'h0000,1'b0,4'd5},  // page 1
        {2'b10,5'd1,5'd30,16'h0000,16'h2222,1'b1,4'd6},  // R6
        {2'b10,5'd1,5'd20,16'h0000,16'h0000,1'b1,4'd7},  // R7 no alias to page1
        {2'b01,5'd2,5'd16,16'h0003,16'h0000,1'b0,4'd8},  // offset 3
        {2'b01,5'd2,5'd17,16'h5A5A,16'h0000,1'b0,4'd8},  // ext[3]
        {2'b10,5'd2,5'd17,16'h0000,16'h5A5A,1'b1,4'd8},  // R8 data port
        {2'b10,5'd2,5'd16,16'h0000,16'h0003,1'b1,4'd8},  // R8 offset port
        {2'b01,5'd2,5'd16,16'h0009,16'h0000,1'b0,4'd8},  // offset 9 unimplemented
        {2'b01,5'd2,5'd17,16'h7777,16'h0000,1'b0,4'd8},  // discarded
        {2'b10,5'd2,5'd17,16'h0000,16'h0000,1'b1,4'd8},  // R8 zero
        {2'b10,5'd2,5'd16,16'h0000,16'h0009,1'b1,4'd8},  // R8 full offset kept
        {2'b01,5'd2,5'd16,16'h0001,16'h0000,1'b0,4'd8},  // offset 1
        {2'b10,5'd2,5'd17,16'h0000,16'h0000,1'b1,4'd8},  // R8 no alias 9->1
        {2'b01,5'd3,5'd4 ,16'hFFFF,16'h0000,1'b0,4'd3},  // R3 foreign write
        {2'b10,5'd3,5'd4 ,16'h0000,16'h0000,1'b0,4'd3},  // R3 foreign read
        {2'b10,5'd1,5'd4 ,16'h0000,16'hABCD,1'b1,4'd3},  // R3 shared reg intact
        {2'b01,5'd2,5'd4 ,16'h1234,16'h0000,1'b0,4'd8},  // R8 other reg ignored
        {2'b10,5'd2,5'd4 ,16'h0000,16'h0000,1'b1,4'd8},  // R8 other reg zero
        {2'b10,5'd0,5'd4 ,16'h0000,16'h0000,1'b0,4'd3}   // R3 address 0
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One MDC cycle: present the bit, sample outputs before the rising edge.
    task automatic clk_bit(input logic b, output logic s_oe, output logic s_out);
        mdio_in = b;
        repeat (HALF) @(negedge clk);
        s_oe  = mdio_oe;
        s_out = mdio_out;
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc = 1'b0;
        bit_no++;
        if (bit_no == drop_bit) access_ready = 1'b0;
    endtask

    // Full frame. stray: driven where not allowed; drv: TA and data all driven.
    task automatic run_frame(input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] wd,
                             input int pre_len, output logic stray,
                             output logic drv, output logic [15:0] rd);
        logic oe, ou;
        logic [13:0] hdr;
        stray = 1'b0; drv = 1'b1; rd = '0; bit_no = 0;
        hdr = {2'b01, op, phy, rg};
        for (int i = 0; i < pre_len; i++) begin clk_bit(1'b1, oe, ou); stray |= oe; end
        for (int i = 13; i >= 0; i--) begin clk_bit(hdr[i], oe, ou); stray |= oe; end
        if (op == 2'b10) begin
            for (int i = 0; i < 19; i++) begin
                clk_bit(1'b1, oe, ou);
                if (i == 0 || i == 18) stray |= oe;
                else if (i == 1) drv &= oe && !ou;
                else begin drv &= oe; rd[17-i] = ou; end
            end
        end else begin
            clk_bit(1'b1, oe, ou); stray |= oe;
            clk_bit(1'b0, oe, ou); stray |= oe;
            for (int i = 15; i >= 0; i--) begin clk_bit(wd[i], oe, ou); stray |= oe; end
        end
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] exp, input string req);
        logic st, dv;
        logic [15:0] rd;
        run_frame(2'b10, phy, rg, 16'h0, 32, st, dv, rd);
        check(!st && dv, {req, " turnaround/drive"}, {15'b0, dv}, 16'h1);
        check(rd == exp, {req, " read data"}, rd, exp);
    endtask

    task automatic no_resp(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wd,
                           input int pre_len, input string req);
        logic st, dv;
        logic [15:0] rd;
        run_frame(op, phy, rg, wd, pre_len, st, dv, rd);
        check(!st && (op != 2'b10 || !dv), {req, " no drive"}, {15'b0, st}, 16'h0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mdio_oe == 1'b0, "R1 reset oe", {15'b0, mdio_oe}, 16'h0);

        // R9: frames inside the post-reset wait are ignored.
        no_resp(2'b01, 5'd1, 5'd4, 16'h1234, 32, "R9 early write");
        no_resp(2'b10, 5'd1, 5'd31, 16'h0, 32, "R9 early read");
        repeat (WAIT) @(negedge clk);
        do_read(5'd1, 5'd4, 16'h0000, "R9 early write dropped");
        do_read(5'd1, 5'd31, 16'h0000, "R1 page reset");

        // Vector walk.
        for (int v = 0; v < NV; v++) begin
            logic [48:0] e;
            logic st, dv;
            logic [15:0] rd;
            string tag;
            e = VEC[v];
            tag = $sformatf("R%0d vec%0d", e[3:0], v);
            run_frame(e[48:47], e[46:42], e[41:37], e[36:21], 32, st, dv, rd);
            if (e[4]) begin
                check(!st && dv, {tag, " drive"}, {15'b0, dv}, 16'h1);
                check(rd == e[20:5], {tag, " data"}, rd, e[20:5]);
            end else begin
                check(!st && (e[48:47] != 2'b10 || !dv), {tag, " no drive"},
                      {15'b0, st}, 16'h0);
            end
        end

        // R10: ready low across the address blocks the frame.
        access_ready = 1'b0;
        no_resp(2'b10, 5'd1, 5'd4, 16'h0, 32, "R10 blocked read");
        no_resp(2'b01, 5'd1, 5'd5, 16'h9999, 32, "R10 blocked write");
        access_ready = 1'b1;
        do_read(5'd1, 5'd5, 16'h0000, "R10 blocked write dropped");

        // R10: ready drops in the data phase of a granted write.
        drop_bit = 55;
        no_resp(2'b01, 5'd1, 5'd6, 16'h4242, 32, "R10 late drop write");
        drop_bit = -1;
        access_ready = 1'b1;
        do_read(5'd1, 5'd6, 16'h4242, "R10 late drop commit");

        // R11: illegal opcodes.
        no_resp(2'b11, 5'd1, 5'd4, 16'h0, 32, "R11 opcode 11");
        no_resp(2'b00, 5'd1, 5'd7, 16'hBEEF, 32, "R11 opcode 00");
        do_read(5'd1, 5'd7, 16'h0000, "R11 nothing written");

        // R2: a 31-bit preamble is not enough (after a clean write).
        no_resp(2'b01, 5'd1, 5'd8, 16'h0001, 32, "R2 lead write");
        no_resp(2'b10, 5'd1, 5'd4, 16'h0, 31, "R2 short preamble");
        do_read(5'd1, 5'd8, 16'h0001, "R2 write landed");

        // R1: reset clears page and storage.
        no_resp(2'b01, 5'd1, 5'd31, 16'h0020, 32, "R5 set page");
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(mdio_oe == 1'b0, "R1 reset oe again", {15'b0, mdio_oe}, 16'h0);
        repeat (WAIT + 10) @(negedge clk);
        do_read(5'd1, 5'd31, 16'h0000, "R1 page cleared");
        do_read(5'd1, 5'd4, 16'h0000, "R1 shared cleared");

        finish_run();
    end
endmodule